// File: doc/BRIEF.md
# Parallel FIFO Handshake Controller

This block joins a byte-wide peripheral bus with no clock of its own to two internal byte buffers, one for each direction. A peripheral writes bytes towards the host by pulsing a high-active write strobe while the transmit-enable flag is low. It reads bytes coming from the host by pulling a low-active read strobe while the receive-full flag is low. On the internal side, bytes written by the peripheral leave on a valid/ready stream called "up". Bytes for the peripheral arrive on a second valid/ready stream called "down".

Both strobes pass through a two-flop synchroniser before any edge is used. A write state machine has two states, WR_READY and WR_BUSY. A falling write strobe seen in WR_READY while the up buffer has room stores the byte and takes transition READY->BUSY. The machine then counts out the busy period and takes transition BUSY->READY. A read state machine has three states: RD_IDLE, RD_LOW_VALID and RD_LOW_EMPTY. A falling read strobe takes IDLE->LOW_VALID if the down buffer holds data, or IDLE->LOW_EMPTY if it does not. The rising strobe returns either state to RD_IDLE. Only the exit from RD_LOW_VALID pops a byte. The data pins are driven with the head byte of the down buffer only while the raw read strobe is low.

Top module: `pfifo_bridge`

## Requirements
- R1: A byte on the data pins is stored when the write strobe `pin_wr` (active high) falls, but only if the write machine is in WR_READY and the up buffer is not full. Any other falling edge is ignored.
- R2: `pin_txe_n` is high whenever the up buffer holds UP_DEPTH (default 384) bytes.
- R3: After each stored byte, `pin_txe_n` is high for exactly BUSY_CYC clock cycles (default 2, at least 2). It then returns low if the up buffer is not full.
- R4: `pin_rxf_n` is low exactly when the down buffer holds at least one byte.
- R5: While `pin_rd_n` is low, the data pins carry the head byte of the down buffer. That byte is removed after `pin_rd_n` rises, as seen through the two-flop synchroniser.
- R6: While `pin_rd_n` is high, the block does not drive the data pins.
- R7: Bytes leave each buffer in the order they entered. `up_valid` is high exactly when the up buffer is not empty, `up_data` is its head, and a byte is removed on each clock where `up_valid` and `up_ready` are both high.
- R8: The down buffer holds DN_DEPTH (default 128) bytes. `dn_ready` is low when it is full, and `dn_data` is taken only on clocks where `dn_valid` and `dn_ready` are both high.
- R9: A read strobe that falls while the down buffer is empty removes nothing, even if a byte arrives before the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_dq | inout | DW | Peripheral data bus |
| pin_rd_n | input | 1 | Peripheral read strobe, active low |
| pin_wr | input | 1 | Peripheral write strobe, byte taken on falling edge |
| pin_txe_n | output | 1 | Write permitted while low |
| pin_rxf_n | output | 1 | Data available to read while low |
| up_data | output | DW | Head byte of the up buffer |
| up_valid | output | 1 | Up buffer not empty |
| up_ready | input | 1 | Host consumer takes the up byte |
| dn_data | input | DW | Byte from host for the peripheral |
| dn_valid | input | 1 | `dn_data` is offered |
| dn_ready | output | 1 | Down buffer has room |

## Verification
Writes are tried in four ways. A lone byte measures the exact length of the busy window. A varied byte pattern (all zeros, all ones, alternating bits) shows both order and bit integrity. A second strobe fired inside the busy window must be lost, which separates a correct busy gate from one that never closes. A run of 384 bytes shows that the full flag holds and that a write made while full is lost. Reads are tried with a short queue, a completely full queue of 128, and a strobe begun on an empty queue with a byte arriving mid-strobe. Together these separate correct pop timing and correct empty handling from versions that pop on the wrong edge or lose the empty decision. The bench also drives a pattern onto the bus while the read strobe is high, which shows the block has let go of the bus.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [0:0] {
        WR_READY,
        WR_BUSY
    } wr_state_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_LOW_VALID,
        RD_LOW_EMPTY
    } rd_state_t;

endpackage

// File: rtl/pfb_sync.sv
module pfb_sync #(
    parameter int         W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/pfb_fifo.sv
module pfb_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= advance(wr_ptr);
            if (do_pop)  rd_ptr <= advance(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pfb_wr_ctl.sv
module pfb_wr_ctl
    import pfb_pkg::*;
#(
    parameter int BUSY_CYC = 2,
    localparam int BW = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_fall,
    input  logic buf_full,
    output logic push,
    output logic txe_n
);

    wr_state_t     state;
    wr_state_t     state_nxt;
    logic [BW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_READY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            WR_READY: if (push)             state_nxt = WR_BUSY;
            WR_BUSY:  if (busy_cnt == '0)   state_nxt = WR_READY;
            default:                        state_nxt = WR_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                busy_cnt <= '0;
        else if (push)             busy_cnt <= BW'(BUSY_CYC - 1);
        else if (busy_cnt != '0)   busy_cnt <= busy_cnt - BW'(1);
    end

    always_comb begin
        push  = (state == WR_READY) && wr_fall && !buf_full;
        txe_n = (state != WR_READY) || buf_full;
    end

endmodule

// File: rtl/pfb_rd_ctl.sv
module pfb_rd_ctl
    import pfb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s,
    input  logic buf_empty,
    output logic pop
);

    rd_state_t state;
    rd_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RD_IDLE:
                if (!rd_s) state_nxt = buf_empty ? RD_LOW_EMPTY : RD_LOW_VALID;
            RD_LOW_VALID:
                if (rd_s) state_nxt = RD_IDLE;
            RD_LOW_EMPTY:
                if (rd_s) state_nxt = RD_IDLE;
            default:
                state_nxt = RD_IDLE;
        endcase
    end

    always_comb begin
        pop = (state == RD_LOW_VALID) && rd_s;
    end

endmodule

// File: rtl/pfifo_bridge.sv
module pfifo_bridge #(
    parameter int DW       = 8,
    parameter int UP_DEPTH = 384,
    parameter int DN_DEPTH = 128,
    parameter int BUSY_CYC = 2,
    localparam int UCW = $clog2(UP_DEPTH + 1),
    localparam int DCW = $clog2(DN_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    inout  wire [DW-1:0]  pin_dq,
    input  logic          pin_rd_n,
    input  logic          pin_wr,
    output logic          pin_txe_n,
    output logic          pin_rxf_n,
    output logic [DW-1:0] up_data,
    output logic          up_valid,
    input  logic          up_ready,
    input  logic [DW-1:0] dn_data,
    input  logic          dn_valid,
    output logic          dn_ready
);

    logic [1:0]    strobe_s;
    logic          rd_s;
    logic          wr_s;
    logic          wr_prev;
    logic          wr_fall;
    logic [DW-1:0] dq_s;

    logic          up_push;
    logic          up_pop;
    logic          up_full;
    logic          up_empty;
    logic [UCW-1:0] up_count;

    logic          dn_push;
    logic          dn_pop;
    logic          dn_full;
    logic          dn_empty;
    logic [DCW-1:0] dn_count;
    logic [DW-1:0] dn_head;

    pfb_sync #(.W(2), .INIT(2'b10)) u_strobe_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pin_rd_n, pin_wr}),
        .q     (strobe_s)
    );

    pfb_sync #(.W(DW), .INIT('0)) u_data_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_dq),
        .q     (dq_s)
    );

    assign rd_s = strobe_s[1];
    assign wr_s = strobe_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_prev <= 1'b0;
        else        wr_prev <= wr_s;
    end

    assign wr_fall = wr_prev && !wr_s;

    pfb_wr_ctl #(.BUSY_CYC(BUSY_CYC)) u_wr_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fall  (wr_fall),
        .buf_full (up_full),
        .push     (up_push),
        .txe_n    (pin_txe_n)
    );

    pfb_fifo #(.DEPTH(UP_DEPTH), .WIDTH(DW)) u_up_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (up_push),
        .wdata (dq_s),
        .pop   (up_pop),
        .rdata (up_data),
        .count (up_count),
        .empty (up_empty),
        .full  (up_full)
    );

    assign up_valid = !up_empty;
    assign up_pop   = up_valid && up_ready;

    pfb_rd_ctl u_rd_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_s      (rd_s),
        .buf_empty (dn_empty),
        .pop       (dn_pop)
    );

    pfb_fifo #(.DEPTH(DN_DEPTH), .WIDTH(DW)) u_dn_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dn_push),
        .wdata (dn_data),
        .pop   (dn_pop),
        .rdata (dn_head),
        .count (dn_count),
        .empty (dn_empty),
        .full  (dn_full)
    );

    assign dn_ready  = !dn_full;
    assign dn_push   = dn_valid && dn_ready;
    assign pin_rxf_n = dn_empty;

    assign pin_dq = pin_rd_n ? {DW{1'bz}} : dn_head;

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
    parameter int UP_DEPTH = 384,
    parameter int UCW      = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pin_txe_n,
    input logic           pin_rxf_n,
    input logic           up_full,
    input logic           up_push,
    input logic [UCW-1:0] up_count,
    input logic           dn_pop,
    input logic           rd_s
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        up_full |-> !up_push);                                     // R1

    AST_FULL_HOLDS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
        up_full |-> pin_txe_n);                                    // R2

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        up_count <= UCW'(UP_DEPTH));                               // R2

    AST_BUSY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        up_push |=> pin_txe_n);                                    // R3

    AST_BUSY_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $past(up_push, 2) |-> pin_txe_n);                          // R3

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dn_pop |-> !pin_rxf_n);                                    // R4

    AST_POP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_pop |-> (rd_s && !$past(rd_s)));                        // R5

endmodule

bind pfifo_bridge pfb_checker #(.UP_DEPTH(UP_DEPTH), .UCW(UCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_txe_n (pin_txe_n),
    .pin_rxf_n (pin_rxf_n),
    .up_full   (up_full),
    .up_push   (up_push),
    .up_count  (up_count),
    .dn_pop    (dn_pop),
    .rd_s      (rd_s)
);

// File: tb/sim_pfifo_bridge.sv
module sim_pfifo_bridge;

    localparam int UPD = 384;
    localparam int DND = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_rd_n = 1'b1;
    logic       pin_wr = 1'b0;
    logic       pin_txe_n;
    logic       pin_rxf_n;
    logic [7:0] up_data;
    logic       up_valid;
    logic       up_ready = 1'b0;
    logic [7:0] dn_data = '0;
    logic       dn_valid = 1'b0;
    logic       dn_ready;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_dq = '0;
    wire  [7:0] pin_dq;

    int checks = 0;
    int errors = 0;

    assign pin_dq = tb_drv ? tb_dq : 8'bzzzzzzzz;

    always #2 clk = ~clk;

    pfifo_bridge u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_dq    (pin_dq),
        .pin_rd_n  (pin_rd_n),
        .pin_wr    (pin_wr),
        .pin_txe_n (pin_txe_n),
        .pin_rxf_n (pin_rxf_n),
        .up_data   (up_data),
        .up_valid  (up_valid),
        .up_ready  (up_ready),
        .dn_data   (dn_data),
        .dn_valid  (dn_valid),
        .dn_ready  (dn_ready)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary_and_end();
    end

    task automatic wait_txe_low();
        for (int i = 0; i < 100 && pin_txe_n; i++) @(negedge clk);
    endtask

    // write one byte; returns cycles txe_n was seen high after the strobe fell
    task automatic wr_byte(input logic [7:0] b, output int busy);
        @(negedge clk);
        tb_dq  = b;
        tb_drv = 1'b1;
        pin_wr = 1'b1;
        repeat (3) @(negedge clk);
        pin_wr = 1'b0;
        busy = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (pin_txe_n) busy++;
        end
        tb_drv = 1'b0;
    endtask

    task automatic up_take(input string req, input logic [7:0] exp);
        for (int i = 0; i < 50 && !up_valid; i++) @(negedge clk);
        check(req, int'(up_valid), 1);
        check(req, int'(up_data), int'(exp));
        up_ready = 1'b1;
        @(negedge clk);
        up_ready = 1'b0;
    endtask

    task automatic dn_send(input logic [7:0] b);
        @(negedge clk);
        for (int i = 0; i < 50 && !dn_ready; i++) @(negedge clk);
        dn_data  = b;
        dn_valid = 1'b1;
        @(negedge clk);
        dn_valid = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk);
        pin_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        b = pin_dq;
        pin_rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 txe_n after reset", int'(pin_txe_n), 0);
        check("R4 rxf_n after reset", int'(pin_rxf_n), 1);
        check("R7 up_valid after reset", int'(up_valid), 0);
        check("R8 dn_ready after reset", int'(dn_ready), 1);
    endtask

    task automatic t_single_write();
        int busy;
        wait_txe_low();
        wr_byte(8'h3C, busy);
        check("R3 busy window length", busy, 2);
        check("R1 txe_n low after busy", int'(pin_txe_n), 0);
        up_take("R1 stored byte", 8'h3C);
        check("R7 up empty after take", int'(up_valid), 0);
    endtask

    task automatic t_write_in_busy();
        wait_txe_low();
        @(negedge clk);
        tb_dq = 8'h11; tb_drv = 1'b1; pin_wr = 1'b1;
        repeat (3) @(negedge clk);
        pin_wr = 1'b0;
        @(negedge clk);
        tb_dq = 8'h22; pin_wr = 1'b1;
        @(negedge clk);
        pin_wr = 1'b0;
        repeat (10) @(negedge clk);
        tb_drv = 1'b0;
        up_take("R1 first byte kept", 8'h11);
        repeat (2) @(negedge clk);
        check("R1 busy-window write ignored", int'(up_valid), 0);
    endtask

    task automatic t_pattern_writes();
        logic [7:0] pat [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        int busy;
        foreach (pat[i]) begin
            wait_txe_low();
            wr_byte(pat[i], busy);
        end
        foreach (pat[i]) up_take("R7 write order", pat[i]);
    endtask

    task automatic t_up_full();
        int busy;
        for (int i = 0; i < UPD; i++) begin
            wait_txe_low();
            wr_byte(8'(i * 7), busy);
        end
        check("R2 txe_n high when full", int'(pin_txe_n), 1);
        wr_byte(8'hEE, busy);
        check("R2 txe_n still high", int'(pin_txe_n), 1);
        up_take("R7 first of full run", 8'h00);
        repeat (2) @(negedge clk);
        check("R2 txe_n low after one drain", int'(pin_txe_n), 0);
        for (int i = 1; i < UPD; i++) up_take("R7 full run order", 8'(i * 7));
        repeat (2) @(negedge clk);
        check("R1 write while full ignored", int'(up_valid), 0);
    endtask

    task automatic t_read_basic();
        logic [7:0] b;
        dn_send(8'hA5);
        dn_send(8'h42);
        dn_send(8'hC3);
        @(negedge clk);
        check("R4 rxf_n low with data", int'(pin_rxf_n), 0);
        tb_dq = 8'h5A; tb_drv = 1'b1;
        @(negedge clk);
        check("R6 bus released while rd_n high", int'(pin_dq), 'h5A);
        tb_drv = 1'b0;
        rd_byte(b); check("R5 read byte 0", int'(b), 'hA5);
        rd_byte(b); check("R5 read byte 1", int'(b), 'h42);
        check("R4 rxf_n low with one left", int'(pin_rxf_n), 0);
        rd_byte(b); check("R5 read byte 2", int'(b), 'hC3);
        check("R4 rxf_n high when empty", int'(pin_rxf_n), 1);
    endtask

    task automatic t_read_empty();
        logic [7:0] b;
        @(negedge clk);
        pin_rd_n = 1'b0;
        repeat (4) @(negedge clk);
        dn_data = 8'h77; dn_valid = 1'b1;
        @(negedge clk);
        dn_valid = 1'b0;
        repeat (2) @(negedge clk);
        pin_rd_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 no pop from empty-start read", int'(pin_rxf_n), 0);
        rd_byte(b);
        check("R9 byte survives", int'(b), 'h77);
        check("R4 rxf_n high after", int'(pin_rxf_n), 1);
    endtask

    task automatic t_dn_full();
        logic [7:0] b;
        for (int i = 0; i < DND; i++) dn_send(8'(i ^ 8'h5A));
        @(negedge clk);
        check("R8 dn_ready low when full", int'(dn_ready), 0);
        dn_data = 8'hEE; dn_valid = 1'b1;
        repeat (3) @(negedge clk);
        dn_valid = 1'b0;
        for (int i = 0; i < DND; i++) begin
            rd_byte(b);
            check("R8 full queue order", int'(b), int'(8'(i ^ 8'h5A)));
        end
        check("R8 offered byte not taken", int'(pin_rxf_n), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_single_write();
        t_write_in_busy();
        t_pattern_writes();
        t_up_full();
        t_read_basic();
        t_read_empty();
        t_dn_full();
        summary_and_end();
    end

endmodule